// File: doc/BRIEF.md
# GPIO Bank with Multi-Mode Pin Event Detection

This block is a bank of general-purpose pins behind a small memory-mapped register port. Software picks the direction of each pin, drives output values and reads back synchronized input levels. The data-out, interrupt-enable and wake-enable vectors each have a pair of alias addresses. A write to an alias sets or clears only the bits written as 1, so no read-modify-write sequence is needed.

Each pin has four event detectors: level low, level high, rising edge and falling edge. Each detector has its own enable and any mix may be on at once. A pin whose detection fires latches a bit in a pending register, and software clears that bit by writing a 1 to it. The bank raises one interrupt line from the pending bits that are enabled. It also raises one wake request whenever an event is detected on a pin whose wake enable is set. Register reads are combinational from the address; writes take effect at the clock edge on which `reg_en` and `reg_we` are both high.

Top module: `gpio_bank`

## Requirements
- R1: After reset all of the following are zero: pending bits, interrupt enables, wake enables, data-out and all four detect-enable vectors. The direction register (0x34) is all ones, so every pin is an input. The config register reads zero.
- R2: Direction register at 0x34: a 1 makes the pin an input (`pad_drive_en` bit 0), a 0 makes it drive (`pad_drive_en` bit 1). `pin_out` always equals the data-out register (0x3C).
- R3: The input register at 0x38 returns `pin_in` through a two-flop synchronizer. A pin change made between edges becomes visible after the second rising clock edge.
- R4: Data-out can be written directly at 0x3C. A write to 0x94 sets, and a write to 0x90 clears, exactly the bits written as 1; bits written as 0 keep their value.
- R5: The interrupt-enable vector at 0x1C can be read and written. A write to 0x64 sets, and a write to 0x60 clears, exactly the bits written as 1.
- R6: The wake-enable vector changes only through 0x84 (set bits written 1) and 0x80 (clear bits written 1). A read of either address returns the current vector.
- R7: Level detect enables sit at 0x40 (pin low) and 0x44 (pin high). An enabled pin at the selected level sets its pending bit on every cycle the level persists.
- R8: Edge detect enables sit at 0x48 (rising) and 0x4C (falling). An edge is a change of the synchronized value from one cycle to the next. All four modes on one pin combine by OR.
- R9: Pending register at 0x18. Each bit written as 1 clears that bit and each bit written as 0 leaves it alone. Once cleared, an edge-detected bit stays clear until a new edge arrives.
- R10: When a clear write and a new detection hit the same pending bit in the same cycle, the bit ends up set. A level that is still present therefore keeps its bit set through a clear.
- R11: `irq` is high exactly when some pending bit has its interrupt enable set.
- R12: `wake` is high in a cycle where a detection fires on a pin with its wake enable set. For an edge it lasts one cycle, in the cycle after the second synchronizer edge.
- R13: Address 0x00 returns the revision, with the major number in bits [7:4] and the minor number in bits [3:0]. Address 0x14 returns 1 in bit 0 (reset complete). Address 0x10 is a CFG_W-bit read/write config register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from the address |
| pin_in | input | N | Asynchronous pin levels |
| pin_out | output | N | Output values for the pins |
| pad_drive_en | output | N | 1 where the pin drives `pin_out` |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
The bench builds the bank with its defaults: 32 pins on a 32-bit data bus, an 8-bit config field and revision 1.8. With all 32 bits live, the set and clear aliases and the pending-register clear can be checked across the full word, including the top bit. Random pin patterns then exercise every mix of level and edge modes. Directed cases pin down the synchronizer latency, the one-cycle wake pulse and the case where a clear and a held level meet in the same cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_REV     = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG     = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_SYS     = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_PEND    = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_IRQEN   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_DIR     = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_PINS    = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_OUT     = 8'h3C;
    localparam logic [ADDR_W-1:0] OFF_DLOW    = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_DHIGH   = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_DRISE   = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_DFALL   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_IE_CLR  = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_IE_SET  = 8'h64;
    localparam logic [ADDR_W-1:0] OFF_WK_CLR  = 8'h80;
    localparam logic [ADDR_W-1:0] OFF_WK_SET  = 8'h84;
    localparam logic [ADDR_W-1:0] OFF_OUT_CLR = 8'h90;
    localparam logic [ADDR_W-1:0] OFF_OUT_SET = 8'h94;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] cur;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = async_in;
        s_d.cur  = s_q.meta;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.cur;
    assign prev = s_q.prev;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int N = 32
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] en_low,
    input  logic [N-1:0] en_high,
    input  logic [N-1:0] en_rise,
    input  logic [N-1:0] en_fall,
    output logic [N-1:0] hit
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic lvl_hit, edge_hit;
        always_comb begin
            lvl_hit  = (en_low[i] & ~cur[i]) | (en_high[i] & cur[i]);
            edge_hit = (en_rise[i] & cur[i] & ~prev[i])
                     | (en_fall[i] & ~cur[i] & prev[i]);
            hit[i]   = lvl_hit | edge_hit;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int         N         = 32,
    parameter int         DW        = 32,
    parameter int         CFG_W     = 8,
    parameter logic [3:0] REV_MAJOR = 4'h1,
    parameter logic [3:0] REV_MINOR = 4'h8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pad_drive_en,
    output logic          irq,
    output logic          wake
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [N-1:0]     dir;
        logic [N-1:0]     dout;
        logic [N-1:0]     ie;
        logic [N-1:0]     wk;
        logic [N-1:0]     dlow;
        logic [N-1:0]     dhigh;
        logic [N-1:0]     drise;
        logic [N-1:0]     dfall;
        logic [N-1:0]     pend;
        logic [CFG_W-1:0] cfg;
    } bank_t;

    bank_t        q, d;
    logic [N-1:0] pin_cur, pin_prev, det, clr_pend, wv;
    logic         wr;

    gpio_sync #(.N(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .cur      (pin_cur),
        .prev     (pin_prev)
    );

    gpio_detect #(.N(N)) u_detect (
        .cur     (pin_cur),
        .prev    (pin_prev),
        .en_low  (q.dlow),
        .en_high (q.dhigh),
        .en_rise (q.drise),
        .en_fall (q.dfall),
        .hit     (det)
    );

    always_comb begin
        d        = q;
        wr       = reg_en & reg_we;
        wv       = reg_wdata[N-1:0];
        clr_pend = '0;
        if (wr) begin
            case (reg_addr)
                OFF_CFG:     d.cfg   = reg_wdata[CFG_W-1:0];
                OFF_PEND:    clr_pend = wv;
                OFF_IRQEN:   d.ie    = wv;
                OFF_DIR:     d.dir   = wv;
                OFF_OUT:     d.dout  = wv;
                OFF_DLOW:    d.dlow  = wv;
                OFF_DHIGH:   d.dhigh = wv;
                OFF_DRISE:   d.drise = wv;
                OFF_DFALL:   d.dfall = wv;
                OFF_IE_CLR:  d.ie    = q.ie & ~wv;
                OFF_IE_SET:  d.ie    = q.ie | wv;
                OFF_WK_CLR:  d.wk    = q.wk & ~wv;
                OFF_WK_SET:  d.wk    = q.wk | wv;
                OFF_OUT_CLR: d.dout  = q.dout & ~wv;
                OFF_OUT_SET: d.dout  = q.dout | wv;
                default: ;
            endcase
        end
        // a detection in the same cycle overrides a clear
        d.pend = (q.pend & ~clr_pend) | det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.dir <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_REV:    reg_rdata = DW'({REV_MAJOR, REV_MINOR});
            OFF_CFG:    reg_rdata = DW'(q.cfg);
            OFF_SYS:    reg_rdata = DW'(1'b1);
            OFF_PEND:   reg_rdata = DW'(q.pend);
            OFF_IRQEN:  reg_rdata = DW'(q.ie);
            OFF_DIR:    reg_rdata = DW'(q.dir);
            OFF_PINS:   reg_rdata = DW'(pin_cur);
            OFF_OUT:    reg_rdata = DW'(q.dout);
            OFF_DLOW:   reg_rdata = DW'(q.dlow);
            OFF_DHIGH:  reg_rdata = DW'(q.dhigh);
            OFF_DRISE:  reg_rdata = DW'(q.drise);
            OFF_DFALL:  reg_rdata = DW'(q.dfall);
            OFF_WK_CLR,
            OFF_WK_SET: reg_rdata = DW'(q.wk);
            default:    reg_rdata = '0;
        endcase
    end

    assign pin_out      = q.dout;
    assign pad_drive_en = ~q.dir;
    assign irq          = |(q.pend & q.ie);
    assign wake         = |(det & q.wk);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int N  = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_en,
    input logic          reg_we,
    input logic [7:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          irq,
    input logic          wake,
    input logic [N-1:0]  pend,
    input logic [N-1:0]  ie,
    input logic [N-1:0]  wk,
    input logic [N-1:0]  det
);
    import gpio_pkg::*;

    logic wr_pend, wr_ie_set, wr_ie_clr;
    assign wr_pend   = reg_en && reg_we && (reg_addr == OFF_PEND);
    assign wr_ie_set = reg_en && reg_we && (reg_addr == OFF_IE_SET);
    assign wr_ie_clr = reg_en && reg_we && (reg_addr == OFF_IE_CLR);

    // R7 R8: a pending bit only appears after a detection
    a_r8_pend_from_detect: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~pend)) |=> ((pend & ~$past(pend) & ~$past(det)) == '0));

    // R9: written ones clear unless a detection coincides
    a_r9_pend_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend & $past(reg_wdata[N-1:0]) & ~$past(det)) == '0));

    // R10: a detection always lands in pending
    a_r10_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|det) |=> ((~pend & $past(det)) == '0));

    // R5: alias writes
    a_r5_ie_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ie_set |=> ((ie & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0])));
    a_r5_ie_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ie_clr |=> ((ie & $past(reg_wdata[N-1:0])) == '0));

    // R11: interrupt needs a pending bit and an enable
    a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|ie) && (|pend)));

    // R12: wake needs a detection and a wake enable
    a_r12_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ((|wk) && (|det)));
endmodule

bind gpio_bank gpio_bank_chk #(.N(N), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .wake      (wake),
    .pend      (q.pend),
    .ie        (q.ie),
    .wk        (q.wk),
    .det       (det)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    localparam int N  = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_en = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pad_drive_en;
    logic          irq, wake;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_bank dut (
        .clk (clk), .rst_n (rst_n), .reg_en (reg_en), .reg_we (reg_we),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pad_drive_en (pad_drive_en),
        .irq (irq), .wake (wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    function automatic logic [31:0] lvl_hits(input logic [31:0] p, input logic [31:0] lo,
                                             input logic [31:0] hi);
        return (lo & ~p) | (hi & p);
    endfunction

    function automatic logic [31:0] edge_hits(input logic [31:0] o, input logic [31:0] n,
                                              input logic [31:0] ri, input logic [31:0] fa);
        return (ri & n & ~o) | (fa & ~n & o);
    endfunction

    initial begin
        cycles(150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, lo, hi, ri, fa, ie, old_p, new_p, exp;
        void'($urandom(32'd4242));
        cycles(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, R13 fixed registers
        rd(8'h18, v); check("R1 pend", v, 32'h0);
        rd(8'h1C, v); check("R1 ie", v, 32'h0);
        rd(8'h34, v); check("R1 dir", v, 32'hFFFF_FFFF);
        rd(8'h3C, v); check("R1 dout", v, 32'h0);
        rd(8'h80, v); check("R1 wake en", v, 32'h0);
        rd(8'h10, v); check("R1 cfg", v, 32'h0);
        check("R1 pad_drive_en", pad_drive_en, 32'h0);
        rd(8'h00, v); check("R13 revision", v, 32'h18);
        rd(8'h14, v); check("R13 sysstatus", v, 32'h1);
        wr(8'h10, 32'h1A5); rd(8'h10, v); check("R13 cfg", v, 32'hA5);

        // R2 direction and output
        wr(8'h34, 32'h0000_FFFF);
        check("R2 drive", pad_drive_en, 32'hFFFF_0000);
        // R4 data-out aliases
        wr(8'h3C, 32'hF0F0_F0F0); check("R2 pin_out", pin_out, 32'hF0F0_F0F0);
        wr(8'h94, 32'h8000_000F); rd(8'h3C, v); check("R4 set", v, 32'hF0F0_F0FF);
        wr(8'h90, 32'hF000_0001); rd(8'h3C, v); check("R4 clear", v, 32'h00F0_F0FE);
        check("R2 pin_out alias", pin_out, 32'h00F0_F0FE);

        // R5 interrupt-enable
        wr(8'h1C, 32'h0000_00F0);
        wr(8'h64, 32'h8000_0001); rd(8'h1C, v); check("R5 set", v, 32'h8000_00F1);
        wr(8'h60, 32'h0000_0030); rd(8'h1C, v); check("R5 clear", v, 32'h8000_00C1);

        // R6 wake-enable
        wr(8'h84, 32'h0000_0108); rd(8'h84, v); check("R6 set read", v, 32'h0000_0108);
        wr(8'h80, 32'h0000_0100); rd(8'h80, v); check("R6 clear read", v, 32'h0000_0008);

        // R3 synchronizer latency
        @(negedge clk) pin_in = 32'h0000_0004;
        @(posedge clk); #1 check("R3 one edge", dut.reg_rdata & 32'h0, 32'h0);
        reg_addr = 8'h38;
        @(negedge clk); check("R3 after 1 edge", reg_rdata, 32'h0);
        @(negedge clk); check("R3 after 2 edges", reg_rdata, 32'h0000_0004);
        @(negedge clk) pin_in = 32'h0;
        cycles(4);

        // R12 wake pulse on rising edge of pin 3 (wake en bit 3)
        wr(8'h48, 32'h0000_0008);
        @(negedge clk) pin_in = 32'h0000_0008;
        @(posedge clk); @(posedge clk);
        @(negedge clk); check("R12 wake pulse", {31'b0, wake}, 32'h1);
        @(negedge clk); check("R12 wake ends", {31'b0, wake}, 32'h0);
        // R8 edge latched; R9 edge bit stays clear after W1C
        rd(8'h18, v); check("R8 rise latched", v, 32'h0000_0008);
        wr(8'h18, 32'h0); rd(8'h18, v); check("R9 zero write", v, 32'h0000_0008);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); check("R9 edge cleared", v, 32'h0);
        check("R11 irq low", {31'b0, irq}, 32'h0);

        // R10 held level survives clear; R11 irq via enable
        wr(8'h44, 32'h0000_0008);
        cycles(1);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); check("R10 level persists", v, 32'h0000_0008);
        check("R11 irq off", {31'b0, irq}, 32'h0);
        wr(8'h64, 32'h0000_0008); check("R11 irq on", {31'b0, irq}, 32'h1);
        check("R12 wake level", {31'b0, wake}, 32'h1);
        wr(8'h80, 32'hFFFF_FFFF);

        // Random mix of detect modes
        old_p = pin_in;
        for (int it = 0; it < 60; it++) begin
            lo = $urandom(); hi = $urandom(); ri = $urandom(); fa = $urandom();
            ie = $urandom();
            if (it % 4 == 0) begin lo = 32'h0; hi = 32'h0; end
            wr(8'h40, lo); wr(8'h44, hi); wr(8'h48, ri); wr(8'h4C, fa);
            wr(8'h1C, ie);
            wr(8'h18, 32'hFFFF_FFFF);
            exp = lvl_hits(old_p, lo, hi);
            rd(8'h18, v); check("R7 R10 level after clear", v, exp);
            check("R11 irq rand", {31'b0, irq}, {31'b0, |(exp & ie)});
            new_p = (it % 5 == 0) ? ~old_p : $urandom();
            @(negedge clk) pin_in = new_p;
            cycles(4);
            exp = exp | lvl_hits(new_p, lo, hi) | edge_hits(old_p, new_p, ri, fa);
            rd(8'h18, v); check("R7 R8 combined", v, exp);
            check("R11 irq rand2", {31'b0, irq}, {31'b0, |(exp & ie)});
            rd(8'h38, v); check("R3 din", v, new_p);
            old_p = new_p;
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule